// File: doc/BRIEF.md
# Five-Stage Delayed-Branch Pipeline Core

This block is a small in-order processor pipeline in which each instruction passes through five stages: fetch, decode, operand fetch, execute and operand store. Every instruction is a fixed 32-bit word. Arithmetic and logic instructions work only on registers. Only load and store touch data memory. Jumps and zero-test branches resolve in decode. The instruction in the slot right after a control transfer always runs, so software places useful work or a no-op there.

Instruction memory is read synchronously: the word at `imem_addr_o` arrives on `imem_rdata_i` one clock later. Data memory behaves the same way. A store writes `dmem_wdata_o` to `dmem_addr_o` on the clock edge where `dmem_we_o` is high. A load presents its address in execute and takes `dmem_rdata_i` one clock later. A read-after-write hazard holds the dependent instruction in decode and feeds bubbles into operand fetch until the producer is close enough for the same-cycle register bypass to cover it.

Instruction layout: opcode [31:24], destination [23:20], source1 [19:16], source2 [15:12], immediate [15:0].

The opcodes are:
- 00 no-op
- 01 add
- 02 subtract
- 03 and
- 04 or
- 05 xor
- 06 load-immediate: destination = zero-extended imm16
- 07 add-immediate: destination = source1 + zero-extended imm[11:0]
- 08 load: destination = mem[source1]
- 09 store: mem[source1] = source2
- 0A jump to imm16
- 0B branch to imm16 when source1 equals zero

Any other opcode behaves as a no-op.

Top module: `dbp_core`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and neither dmem_we_o nor dmem_re_o is asserted. The registers clear to zero. The first fetch after release is from word 0.
- R2: With no hazard and no control transfer, imem_addr_o advances by one word every clock.
- R3: Opcodes 01 to 07 write the result of add, subtract, and, or, xor, load-immediate or add-immediate into the destination register.
- R4: Register 0 always reads as zero. Writes that target it are discarded.
- R5: Only opcode 09 asserts dmem_we_o, and only opcode 08 asserts dmem_re_o. A store writes source2 to the address held in source1.
- R6: A jump fetches the next word as its delay slot, and that slot executes. The fetch after the slot comes from the jump target. The words between the slot and the target do not execute.
- R7: A zero-test branch is taken only when source1 is zero. Its delay slot executes whether or not the branch is taken. A branch that is not taken continues with the word after the slot.
- R8: An instruction whose source is written by the immediately preceding instruction is held in decode for one cycle, so imem_addr_o repeats one value. It still gets the new value.
- R9: A branch that tests a register written by the preceding instruction waits two cycles in decode. It then resolves on the written value.
- R10: An instruction that uses a loaded value right after the load gets the loaded data.
- R11: Opcode 00 and undefined opcodes change neither registers nor data memory, whatever their register fields hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | IMEM_AW | Instruction word address |
| imem_rdata_i | input | 32 | Instruction word, valid one cycle after its address |
| dmem_addr_o | output | DMEM_AW | Data word address for load or store |
| dmem_re_o | output | 1 | Load read request |
| dmem_we_o | output | 1 | Store write enable |
| dmem_wdata_o | output | XLEN | Store data |
| dmem_rdata_i | input | XLEN | Load data, valid one cycle after the request |

## Verification
The bench builds the core with XLEN 32 and with 8-bit instruction and data word addresses. This places branch targets, store addresses and whole test programs inside 256-word bench memories, so results can be read back from the data memory after each program. Fetch addresses are sampled cycle by cycle after reset. This makes the one-cycle operand interlock, the two-cycle branch interlock and the redirect after the delay slot visible as exact address sequences. The programs also exercise loads feeding the next instruction, both outcomes of the zero branch, writes to register 0 and opcodes that have no definition.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 8;
  localparam int unsigned RIDX_W  = 4;
  localparam int unsigned NREG    = 1 << RIDX_W;

  localparam logic [OPC_W-1:0] OPC_NOP  = 8'h00;
  localparam logic [OPC_W-1:0] OPC_ADD  = 8'h01;
  localparam logic [OPC_W-1:0] OPC_SUB  = 8'h02;
  localparam logic [OPC_W-1:0] OPC_AND  = 8'h03;
  localparam logic [OPC_W-1:0] OPC_OR   = 8'h04;
  localparam logic [OPC_W-1:0] OPC_XOR  = 8'h05;
  localparam logic [OPC_W-1:0] OPC_LI   = 8'h06;
  localparam logic [OPC_W-1:0] OPC_ADDI = 8'h07;
  localparam logic [OPC_W-1:0] OPC_LD   = 8'h08;
  localparam logic [OPC_W-1:0] OPC_ST   = 8'h09;
  localparam logic [OPC_W-1:0] OPC_JMP  = 8'h0A;
  localparam logic [OPC_W-1:0] OPC_BZ   = 8'h0B;

  typedef struct packed {
    logic wr_rd;  // writes destination
    logic use_a;  // reads source1
    logic use_b;  // reads source2
    logic ld;
    logic st;
    logic jmp;
    logic bz;
  } dec_t;
endpackage

// File: rtl/dbp_decode.sv
module dbp_decode
  import dbp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o = '0;
    case (instr_i[31:24])
      OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_XOR: begin
        dec_o.wr_rd = 1'b1; dec_o.use_a = 1'b1; dec_o.use_b = 1'b1;
      end
      OPC_LI:   dec_o.wr_rd = 1'b1;
      OPC_ADDI: begin dec_o.wr_rd = 1'b1; dec_o.use_a = 1'b1; end
      OPC_LD:   begin dec_o.wr_rd = 1'b1; dec_o.use_a = 1'b1; dec_o.ld = 1'b1; end
      OPC_ST:   begin dec_o.use_a = 1'b1; dec_o.use_b = 1'b1; dec_o.st = 1'b1; end
      OPC_JMP:  dec_o.jmp = 1'b1;
      OPC_BZ:   begin dec_o.use_a = 1'b1; dec_o.bz = 1'b1; end
      default:  dec_o = '0;
    endcase
  end
endmodule

// File: rtl/dbp_alu.sv
module dbp_alu
  import dbp_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [OPC_W-1:0] op_i,
  input  logic [XLEN-1:0]  a_i,
  input  logic [XLEN-1:0]  b_i,
  input  logic [15:0]      imm_i,
  output logic [XLEN-1:0]  res_o
);
  always_comb begin
    case (op_i)
      OPC_ADD:  res_o = a_i + b_i;
      OPC_SUB:  res_o = a_i - b_i;
      OPC_AND:  res_o = a_i & b_i;
      OPC_OR:   res_o = a_i | b_i;
      OPC_XOR:  res_o = a_i ^ b_i;
      OPC_LI:   res_o = XLEN'(imm_i);
      OPC_ADDI: res_o = a_i + XLEN'(imm_i[11:0]);
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/dbp_regfile.sv
module dbp_regfile
  import dbp_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NRD  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [RIDX_W-1:0]           waddr_i,
  input  logic [XLEN-1:0]             wdata_i,
  input  logic [NRD-1:0][RIDX_W-1:0]  raddr_i,
  output logic [NRD-1:0][XLEN-1:0]    rdata_o
);
  logic [XLEN-1:0] regs_q [NREG];
  logic            wr_en;

  assign wr_en = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  // write-before-read: a same-cycle write is visible to every read port
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr_i[p] == '0)                 rdata_o[p] = '0;
      else if (wr_en && waddr_i == raddr_i[p]) rdata_o[p] = wdata_i;
      else                                  rdata_o[p] = regs_q[raddr_i[p]];
    end
  end

  p_reg0_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[0] == '0);
endmodule

// File: rtl/dbp_core.sv
module dbp_core
  import dbp_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned IMEM_AW = 16,
  parameter int unsigned DMEM_AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic [IMEM_AW-1:0]   imem_addr_o,
  input  logic [INSTR_W-1:0]   imem_rdata_i,
  output logic [DMEM_AW-1:0]   dmem_addr_o,
  output logic                 dmem_re_o,
  output logic                 dmem_we_o,
  output logic [XLEN-1:0]      dmem_wdata_o,
  input  logic [XLEN-1:0]      dmem_rdata_i
);
  localparam int unsigned NRD = 3;  // 0: OF src1, 1: OF src2, 2: ID branch test

  // fetch / decode
  logic [IMEM_AW-1:0] pc_q, id_pc_q, br_target;
  logic               id_valid_q, stall, br_taken;
  logic [INSTR_W-1:0] id_instr;
  dec_t               id_dec;
  logic [RIDX_W-1:0]  id_rs1, id_rs2;

  // operand fetch
  logic               of_valid_q;
  logic [INSTR_W-1:0] of_instr_q;
  dec_t               of_dec_q;
  logic [RIDX_W-1:0]  of_rd, of_rs1, of_rs2;

  // execute
  logic               ex_valid_q;
  dec_t               ex_dec_q;
  logic [OPC_W-1:0]   ex_op_q;
  logic [RIDX_W-1:0]  ex_rd_q;
  logic [XLEN-1:0]    ex_a_q, ex_b_q, ex_res;
  logic [15:0]        ex_imm_q;

  // operand store
  logic               os_wr_q, os_ld_q;
  logic [RIDX_W-1:0]  os_rd_q;
  logic [XLEN-1:0]    os_res_q, wb_data;

  logic [NRD-1:0][RIDX_W-1:0] rf_raddr;
  logic [NRD-1:0][XLEN-1:0]   rf_rdata;
  logic                       of_writes, ex_writes;

  assign id_instr  = imem_rdata_i;
  assign id_rs1    = id_instr[19:16];
  assign id_rs2    = id_instr[15:12];
  assign br_target = id_instr[IMEM_AW-1:0];
  assign of_rd     = of_instr_q[23:20];
  assign of_rs1    = of_instr_q[19:16];
  assign of_rs2    = of_instr_q[15:12];

  dbp_decode u_dec (.instr_i(id_instr), .dec_o(id_dec));

  assign of_writes = of_valid_q && of_dec_q.wr_rd && (of_rd != '0);
  assign ex_writes = ex_valid_q && ex_dec_q.wr_rd && (ex_rd_q != '0);

  // operands are read in OF; a producer one stage ahead must reach OS first.
  // the branch test reads in ID, so producers in OF and EX both block it.
  always_comb begin
    stall = 1'b0;
    if (id_valid_q) begin
      if (id_dec.use_a && of_writes && id_rs1 == of_rd) stall = 1'b1;
      if (id_dec.use_b && of_writes && id_rs2 == of_rd) stall = 1'b1;
      if (id_dec.bz && ex_writes && id_rs1 == ex_rd_q)  stall = 1'b1;
    end
  end

  assign br_taken = id_valid_q && !stall &&
                    (id_dec.jmp || (id_dec.bz && rf_rdata[2] == '0));

  // re-present the held word so it reappears next cycle
  assign imem_addr_o = stall ? id_pc_q : pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      id_pc_q    <= '0;
      id_valid_q <= 1'b0;
    end else begin
      id_valid_q <= 1'b1;
      if (!stall) begin
        id_pc_q <= pc_q;
        pc_q    <= br_taken ? br_target : pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      of_valid_q <= 1'b0;
      of_instr_q <= '0;
      of_dec_q   <= '0;
    end else begin
      of_valid_q <= id_valid_q && !stall;
      of_instr_q <= stall ? '0 : id_instr;
      of_dec_q   <= (id_valid_q && !stall) ? id_dec : '0;
    end
  end

  assign rf_raddr[0] = of_rs1;
  assign rf_raddr[1] = of_rs2;
  assign rf_raddr[2] = id_rs1;

  dbp_regfile #(.XLEN(XLEN), .NRD(NRD)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (os_wr_q),
    .waddr_i (os_rd_q),
    .wdata_i (wb_data),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_valid_q <= 1'b0;
      ex_dec_q   <= '0;
      ex_op_q    <= '0;
      ex_rd_q    <= '0;
      ex_a_q     <= '0;
      ex_b_q     <= '0;
      ex_imm_q   <= '0;
    end else begin
      ex_valid_q <= of_valid_q;
      ex_dec_q   <= of_valid_q ? of_dec_q : '0;
      ex_op_q    <= of_instr_q[31:24];
      ex_rd_q    <= of_rd;
      ex_a_q     <= rf_rdata[0];
      ex_b_q     <= rf_rdata[1];
      ex_imm_q   <= of_instr_q[15:0];
    end
  end

  dbp_alu #(.XLEN(XLEN)) u_alu (
    .op_i  (ex_op_q),
    .a_i   (ex_a_q),
    .b_i   (ex_b_q),
    .imm_i (ex_imm_q),
    .res_o (ex_res)
  );

  assign dmem_addr_o  = ex_a_q[DMEM_AW-1:0];
  assign dmem_we_o    = ex_valid_q && ex_dec_q.st;
  assign dmem_re_o    = ex_valid_q && ex_dec_q.ld;
  assign dmem_wdata_o = ex_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_wr_q  <= 1'b0;
      os_ld_q  <= 1'b0;
      os_rd_q  <= '0;
      os_res_q <= '0;
    end else begin
      os_wr_q  <= ex_valid_q && ex_dec_q.wr_rd;
      os_ld_q  <= ex_valid_q && ex_dec_q.ld;
      os_rd_q  <= ex_rd_q;
      os_res_q <= ex_res;
    end
  end

  assign wb_data = os_ld_q ? dmem_rdata_i : os_res_q;

  p_fetch_from_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> imem_addr_o == '0);

  p_mem_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dmem_we_o && dmem_re_o));

  p_redirect_after_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |=> (stall || imem_addr_o == $past(br_target)));

  p_hold_on_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> (id_pc_q == $past(id_pc_q) && pc_q == $past(pc_q) && !of_valid_q));

  p_operand_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (of_valid_q && of_dec_q.use_a && of_rs1 != '0) |-> !(ex_writes && ex_rd_q == of_rs1));

  p_branch_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken |-> !(of_writes && of_rd == id_rs1 && id_dec.bz));
endmodule

// File: tb/dbp_core_bench.sv
`timescale 1ns/1ps
module dbp_core_bench;
  localparam int unsigned IAW = 8;
  localparam int unsigned DAW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [IAW-1:0]  imem_addr_o;
  logic [31:0]     imem_rdata_i;
  logic [DAW-1:0]  dmem_addr_o;
  logic            dmem_re_o, dmem_we_o;
  logic [31:0]     dmem_wdata_o, dmem_rdata_i;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  int n_chk = 0, n_bad = 0, n_st = 0;

  always #2 clk_i = ~clk_i;

  dbp_core #(.XLEN(32), .IMEM_AW(IAW), .DMEM_AW(DAW)) u_dbp_core (
    .clk_i, .rst_ni, .imem_addr_o, .imem_rdata_i,
    .dmem_addr_o, .dmem_re_o, .dmem_we_o, .dmem_wdata_o, .dmem_rdata_i
  );

  always @(posedge clk_i) begin
    imem_rdata_i <= imem[imem_addr_o];
    dmem_rdata_i <= dmem[dmem_addr_o];
    if (dmem_we_o) begin
      dmem[dmem_addr_o] <= dmem_wdata_o;
      if (rst_ni) n_st = n_st + 1;
    end
  end

  function automatic logic [31:0] rr(input logic [7:0] op, input logic [3:0] d, a, b);
    return {op, d, a, b, 12'h0};
  endfunction
  function automatic logic [31:0] li(input logic [3:0] d, input logic [15:0] v);
    return {8'h06, d, 4'h0, v};
  endfunction
  function automatic logic [31:0] addi(input logic [3:0] d, a, input logic [11:0] v);
    return {8'h07, d, a, 4'h0, v};
  endfunction
  function automatic logic [31:0] ld(input logic [3:0] d, a);
    return {8'h08, d, a, 16'h0};
  endfunction
  function automatic logic [31:0] st(input logic [3:0] a, dat);
    return {8'h09, 4'h0, a, dat, 12'h0};
  endfunction
  function automatic logic [31:0] jmp(input logic [15:0] t);
    return {8'h0A, 8'h00, t};
  endfunction
  function automatic logic [31:0] bz(input logic [3:0] a, input logic [15:0] t);
    return {8'h0B, 4'h0, a, t};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mems();
    for (int i = 0; i < 256; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  // leaves time just after the negedge at which reset was released
  task automatic start();
    @(negedge clk_i);
    rst_ni = 1'b0;
    n_st = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
  endtask

  task automatic step();
    @(negedge clk_i);
    #0.5;
  endtask

  task automatic t_reset();
    clear_mems();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R1 fetch addr in reset", 32'(imem_addr_o), 32'h0);
    check("R1 no mem access in reset", {30'h0, dmem_we_o, dmem_re_o}, 32'h0);
  endtask

  task automatic t_seq_fetch();
    clear_mems();
    for (int i = 0; i < 8; i++) imem[i] = li(4'(i + 1), 16'(i));
    start();
    for (int k = 0; k < 8; k++) begin
      check($sformatf("R2 fetch step %0d", k), 32'(imem_addr_o), 32'(k));
      step();
    end
  endtask

  task automatic t_alu();
    clear_mems();
    imem[0]  = li(1, 16'h1234);
    imem[1]  = li(2, 16'h00F0);
    imem[2]  = li(10, 16'h0040);
    imem[3]  = rr(8'h01, 3, 1, 2);
    imem[4]  = rr(8'h02, 4, 1, 2);
    imem[5]  = rr(8'h03, 5, 1, 2);
    imem[6]  = rr(8'h04, 6, 1, 2);
    imem[7]  = rr(8'h05, 7, 1, 2);
    imem[8]  = addi(8, 1, 12'h00F);
    imem[9]  = st(10, 3);  imem[10] = addi(10, 10, 1);
    imem[11] = st(10, 4);  imem[12] = addi(10, 10, 1);
    imem[13] = st(10, 5);  imem[14] = addi(10, 10, 1);
    imem[15] = st(10, 6);  imem[16] = addi(10, 10, 1);
    imem[17] = st(10, 7);  imem[18] = addi(10, 10, 1);
    imem[19] = st(10, 8);
    start();
    repeat (60) step();
    check("R3 add",  dmem[8'h40], 32'h1234 + 32'h00F0);
    check("R3 sub",  dmem[8'h41], 32'h1234 - 32'h00F0);
    check("R3 and",  dmem[8'h42], 32'h1234 & 32'h00F0);
    check("R3 or",   dmem[8'h43], 32'h1234 | 32'h00F0);
    check("R3 xor",  dmem[8'h44], 32'h1234 ^ 32'h00F0);
    check("R3 addi", dmem[8'h45], 32'h1234 + 32'h000F);
  endtask

  task automatic t_reg_zero();
    clear_mems();
    dmem[0] = 32'hDEAD_BEEF;
    dmem[5] = 32'hDEAD_BEEF;
    imem[0] = li(0, 16'h0077);
    imem[1] = addi(0, 0, 12'h005);
    imem[2] = rr(8'h01, 1, 0, 0);
    imem[3] = li(2, 16'h0005);
    imem[4] = st(0, 1);
    imem[5] = st(2, 0);
    start();
    repeat (40) step();
    check("R4 r0 as address and sum", dmem[0], 32'h0);
    check("R4 r0 as store data", dmem[5], 32'h0);
  endtask

  task automatic t_load_store();
    clear_mems();
    dmem[8'h20] = 32'hCAFE_0010;
    imem[0] = li(1, 16'h0020);
    imem[1] = ld(2, 1);
    imem[2] = addi(3, 2, 12'h001);
    imem[3] = li(4, 16'h0021);
    imem[4] = st(4, 3);
    imem[5] = st(1, 2);
    start();
    repeat (40) step();
    check("R10 load-use value", dmem[8'h21], 32'hCAFE_0011);
    check("R5 store of loaded data", dmem[8'h20], 32'hCAFE_0010);
    check("R5 store count", 32'(n_st), 32'd2);
  endtask

  task automatic t_jump();
    clear_mems();
    imem[0] = li(1, 16'h0030);
    imem[1] = jmp(16'd5);
    imem[2] = li(2, 16'h0011);
    imem[3] = li(3, 16'h0022);
    imem[4] = li(2, 16'h0033);
    imem[5] = st(1, 2);
    imem[6] = addi(1, 1, 12'h001);
    imem[7] = st(1, 3);
    start();
    step();
    step();
    check("R6 delay slot fetched", 32'(imem_addr_o), 32'd2);
    step();
    check("R6 target fetched after slot", 32'(imem_addr_o), 32'd5);
    repeat (40) step();
    check("R6 slot executed, skipped word not", dmem[8'h30], 32'h0011);
    check("R6 word between slot and target skipped", dmem[8'h31], 32'h0);
  endtask

  task automatic t_branch();
    clear_mems();
    imem[0]  = li(10, 16'h0050);
    imem[1]  = li(1, 16'h0000);
    imem[2]  = li(2, 16'h0007);
    imem[3]  = 32'h0;
    imem[4]  = bz(1, 16'd9);
    imem[5]  = li(3, 16'h0005);
    imem[6]  = li(4, 16'h0099);
    imem[7]  = li(4, 16'h0098);
    imem[8]  = 32'h0;
    imem[9]  = bz(2, 16'd30);
    imem[10] = li(5, 16'h0006);
    imem[11] = li(6, 16'h0077);
    imem[12] = st(10, 3);  imem[13] = addi(10, 10, 1);
    imem[14] = st(10, 4);  imem[15] = addi(10, 10, 1);
    imem[16] = st(10, 5);  imem[17] = addi(10, 10, 1);
    imem[18] = st(10, 6);
    imem[30] = li(6, 16'h00EE);
    start();
    repeat (60) step();
    check("R7 taken slot runs", dmem[8'h50], 32'h0005);
    check("R7 taken skips fall-through", dmem[8'h51], 32'h0);
    check("R7 not-taken slot runs", dmem[8'h52], 32'h0006);
    check("R7 not-taken continues", dmem[8'h53], 32'h0077);
  endtask

  task automatic t_raw_stall();
    logic [31:0] exp_a [4] = '{0, 1, 1, 2};
    clear_mems();
    imem[0] = li(1, 16'h0005);
    imem[1] = addi(2, 1, 12'h003);
    imem[2] = li(4, 16'h0061);
    imem[3] = st(4, 2);
    start();
    for (int k = 0; k < 4; k++) begin
      check($sformatf("R8 fetch trace step %0d", k), 32'(imem_addr_o), exp_a[k]);
      step();
    end
    repeat (30) step();
    check("R8 dependent gets new value", dmem[8'h61], 32'h0008);
  endtask

  task automatic t_branch_stall();
    logic [31:0] exp_a [7] = '{0, 1, 1, 1, 2, 6, 7};
    clear_mems();
    imem[0] = li(1, 16'h0000);
    imem[1] = bz(1, 16'd6);
    imem[2] = li(2, 16'h0044);
    imem[3] = li(2, 16'h0055);
    imem[6] = li(3, 16'h0060);
    imem[7] = st(3, 2);
    start();
    for (int k = 0; k < 7; k++) begin
      check($sformatf("R9 fetch trace step %0d", k), 32'(imem_addr_o), exp_a[k]);
      step();
    end
    repeat (30) step();
    check("R9 branch resolved on new value", dmem[8'h60], 32'h0044);
  endtask

  task automatic t_nop();
    clear_mems();
    imem[0] = li(1, 16'h0070);
    imem[1] = li(2, 16'h0012);
    imem[2] = 32'h00_2_1_1_000;
    imem[3] = 32'hEE_2_1_1_FFF;
    imem[4] = 32'hFF_2_2_2_222;
    imem[5] = st(1, 2);
    start();
    repeat (40) step();
    check("R11 register untouched by no-op/undefined", dmem[8'h70], 32'h0012);
    check("R11 no extra memory writes", 32'(n_st), 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual 20000 cycles, expected completion sooner");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_seq_fetch();
    t_alu();
    t_reg_zero();
    t_load_store();
    t_jump();
    t_branch();
    t_raw_stall();
    t_branch_stall();
    t_nop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule